// File: doc/BRIEF.md
# Serial EEPROM Program Image Loader

This block fills an on-chip program RAM, which takes the place of a mask ROM, from an external two-wire serial EEPROM. It is the only master on the bus. It drives the clock line and pulls the data line low or lets it float through an output-enable. The whole image is fetched in one sequential read that starts at EEPROM byte 0. Each pair of bytes is packed into one 12-bit program word, and the word goes to the RAM through a single-cycle write strobe with a page/step address. The default RAM holds 16 pages of 256 steps.

While a load is running, the block holds the CPU and its peripherals in system reset. Reset is released only after the image has arrived intact. The image is checked three ways: every address-phase acknowledge must be present, each high byte must have a clear upper nibble, and a trailing 16-bit checksum must match. If any check fails, the error output rises and reset stays asserted. A load begins on its own after power-on. It begins again on any rising edge of the reload input, and this edge aborts a transfer that is still in progress.

Top module: `prom_boot_loader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `sys_rst_o` is 1, `err_o` is 0, `scl_o` is 1 and `sda_oe_o` is 0. A load then starts without any other stimulus.
- R2: The bus transfer follows this order: START, the byte `{DEV_ID,0}` (0xA0 by default), two address bytes of 0x00, a repeated START, `{DEV_ID,1}` (0xA1), and then a sequential read of 2·WORDS+2 bytes. The master ACKs every read byte except the last one, which it NACKs. A STOP follows.
- R3: `scl_o` and `sda_oe_o` never change in the same clock cycle, so data bits change only while SCL is low.
- R4: EEPROM byte 2k is the high byte of word k, and its low nibble holds bits 11:8. Byte 2k+1 holds bits 7:0. Word k is written with `mem_page_o` = k[AW-1:STEP_W] and `mem_step_o` = k[STEP_W-1:0], in ascending k. Each write is a one-cycle `mem_we_o` pulse. Every word is written, including page 1 step 0 (the start address) and the steps that follow it in page 1.
- R5: `mem_we_o` is high only while `sys_rst_o` is high.
- R6: After a load passes all checks, the STOP completes, `sys_rst_o` falls to 0, `err_o` stays 0, and the bus is left released (`scl_o`=1, `sda_oe_o`=0).
- R7: If any high byte has a nonzero upper nibble, `err_o` becomes 1 at the end of the load and `sys_rst_o` stays 1. The words are still written with bits 11:8 taken from the low nibble.
- R8: The two bytes after the image form a checksum, high byte first. If it differs from the 16-bit wrap-around sum of all image bytes, `err_o` becomes 1 and `sys_rst_o` stays 1.
- R9: If any byte of the address phase is not acknowledged, the master issues STOP and writes no word. `err_o` becomes 1 and `sys_rst_o` stays 1.
- R10: A rising edge on `reload_i` sets `sys_rst_o` within four clock cycles. It clears `err_o` and runs a complete new load from EEPROM address 0.
- R11: A reload edge during a transfer ends the transfer. In the read phase the next byte is NACKed before the STOP. The load then restarts from address 0 and rewrites every word, and `sys_rst_o` stays high throughout.
- R12: `err_o` high implies `sys_rst_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| reload_i | input | 1 | Asynchronous reload request, acts on its rising edge |
| scl_o | output | 1 | Serial clock driven to the EEPROM |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sys_rst_o | output | 1 | System reset for the CPU and peripherals, active high |
| err_o | output | 1 | Image check failed |
| mem_we_o | output | 1 | One-cycle program RAM write strobe |
| mem_page_o | output | PAGE_W | Page of the word being written |
| mem_step_o | output | STEP_W | Step within the page |
| mem_data_o | output | 12 | Assembled program word |

## Verification
Four rules are checked by assertions on every clock cycle: SCL and the data enable never move together, writes happen only under reset, an error always keeps reset asserted, and the bus sits released whenever reset is off. The write strobe is also checked to be a single-cycle pulse. The remaining behaviour needs a modelled EEPROM and can only be shown by the bench's scenarios. That covers the exact byte order and ACK/NACK pattern, the packing and addressing of every word, the three kinds of image error, and the reload cases both after a finished load and during a read.

// File: rtl/boot_pkg.sv
package boot_pkg;

   typedef enum logic [1:0] {
      OP_START,
      OP_STOP,
      OP_WR,
      OP_RD
   } bus_op_t;

   typedef enum logic [3:0] {
      SQ_START1,
      SQ_DEVW,
      SQ_AH,
      SQ_AL,
      SQ_START2,
      SQ_DEVR,
      SQ_READ,
      SQ_STOP,
      SQ_DONE,
      SQ_FAIL
   } seq_t;

endpackage

// File: rtl/boot_tick.sv
module boot_tick #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_full
         assign tick_o = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         assign tick_o = (cnt == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (tick_o) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/boot_bus_engine.sv
module boot_bus_engine import boot_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       go_i,
   input  bus_op_t    op_i,
   input  logic [7:0] tx_i,
   input  logic       nak_i,
   input  logic       sda_i,
   output logic       scl_o,
   output logic       sda_oe_o,
   output logic       done_o,
   output logic [8:0] rx_o
);
   logic       busy;
   bus_op_t    op_q;
   logic [1:0] ph;
   logic [3:0] bitn;
   logic [8:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         op_q     <= OP_STOP;
         ph       <= 2'd0;
         bitn     <= 4'd0;
         sh       <= '1;
         rx_o     <= '0;
         scl_o    <= 1'b1;
         sda_oe_o <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy) begin
            if (go_i) begin
               busy <= 1'b1;
               op_q <= op_i;
               ph   <= 2'd0;
               bitn <= 4'd0;
               sh   <= (op_i == OP_RD) ? {8'hFF, nak_i} : {tx_i, 1'b1};
            end
         end else if (tick_i) begin
            ph <= ph + 2'd1;
            unique case (op_q)
               OP_START: begin
                  unique case (ph)
                     2'd0: begin scl_o <= 1'b0; sda_oe_o <= 1'b0; end
                     2'd1: scl_o <= 1'b1;
                     2'd2: sda_oe_o <= 1'b1;
                     default: begin scl_o <= 1'b0; busy <= 1'b0; done_o <= 1'b1; end
                  endcase
               end
               OP_STOP: begin
                  unique case (ph)
                     2'd0: sda_oe_o <= 1'b1;
                     2'd1: scl_o <= 1'b1;
                     2'd2: sda_oe_o <= 1'b0;
                     default: begin busy <= 1'b0; done_o <= 1'b1; end
                  endcase
               end
               default: begin
                  unique case (ph)
                     2'd0: sda_oe_o <= ~sh[8];
                     2'd1: scl_o <= 1'b1;
                     2'd2: rx_o <= {rx_o[7:0], sda_i};
                     default: begin
                        scl_o <= 1'b0;
                        sh    <= {sh[7:0], 1'b1};
                        if (bitn == 4'd8) begin
                           busy   <= 1'b0;
                           done_o <= 1'b1;
                        end else begin
                           bitn <= bitn + 4'd1;
                        end
                     end
                  endcase
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack #(
   parameter int PAGE_W = 4,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              vld_i,
   input  logic [7:0]        byte_i,
   output logic              last_o,
   output logic              bad_o,
   output logic              we_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [STEP_W-1:0] step_o,
   output logic [11:0]       data_o
);
   localparam int AW    = PAGE_W + STEP_W;
   localparam int IMG_B = 2 ** (AW + 1);
   localparam int NB    = IMG_B + 2;
   localparam int CW    = $clog2(NB);

   logic [CW-1:0] cnt;
   logic [3:0]    hi_q;
   logic          fmt_bad;
   logic [15:0]   sum, chk;

   assign last_o = (cnt == CW'(NB - 1));
   assign bad_o  = fmt_bad | (sum != chk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; hi_q <= '0; fmt_bad <= 1'b0; sum <= '0; chk <= '0;
         we_o <= 1'b0; page_o <= '0; step_o <= '0; data_o <= '0;
      end else begin
         we_o <= 1'b0;
         if (clr_i) begin
            cnt <= '0; hi_q <= '0; fmt_bad <= 1'b0; sum <= '0; chk <= '0;
         end else if (vld_i) begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(IMG_B)) begin
               sum <= sum + {8'd0, byte_i};
               if (!cnt[0]) begin
                  hi_q <= byte_i[3:0];
                  if (byte_i[7:4] != 4'd0) fmt_bad <= 1'b1;
               end else begin
                  we_o   <= 1'b1;
                  page_o <= cnt[AW:STEP_W+1];
                  step_o <= cnt[STEP_W:1];
                  data_o <= {hi_q, byte_i};
               end
            end else if (cnt == CW'(IMG_B)) begin
               chk[15:8] <= byte_i;
            end else begin
               chk[7:0] <= byte_i;
            end
         end
      end
   end
endmodule

// File: rtl/prom_boot_loader.sv
module prom_boot_loader import boot_pkg::*; #(
   parameter int         CLK_DIV = 8,
   parameter int         PAGE_W  = 4,
   parameter int         STEP_W  = 8,
   parameter logic [6:0] DEV_ID  = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_i,
   output logic              scl_o,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              sys_rst_o,
   output logic              err_o,
   output logic              mem_we_o,
   output logic [PAGE_W-1:0] mem_page_o,
   output logic [STEP_W-1:0] mem_step_o,
   output logic [11:0]       mem_data_o
);
   localparam int AW = PAGE_W + STEP_W;

   generate
      if (CLK_DIV < 1) begin : g_div_bad
         $error("CLK_DIV below 1");
      end
      if (AW > 14 || PAGE_W < 1 || STEP_W < 1) begin : g_aw_bad
         $error("address split out of range");
      end
   endgenerate

   logic       tick, go_q, nak_q, eng_done, issued, pend, bad_ack, clr_q;
   logic [8:0] eng_rx;
   logic [7:0] tx_q;
   logic [2:0] rl_sync;
   logic       rl_edge, pk_last, pk_bad;
   bus_op_t    op_q;
   seq_t       st;

   assign rl_edge = rl_sync[1] & ~rl_sync[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rl_sync <= '0;
      else        rl_sync <= {rl_sync[1:0], reload_i};
   end

   boot_tick #(.DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   boot_bus_engine u_eng (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(go_q), .op_i(op_q),
      .tx_i(tx_q), .nak_i(nak_q), .sda_i(sda_i), .scl_o(scl_o),
      .sda_oe_o(sda_oe_o), .done_o(eng_done), .rx_o(eng_rx)
   );

   boot_word_pack #(.PAGE_W(PAGE_W), .STEP_W(STEP_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_q),
      .vld_i(eng_done && st == SQ_READ), .byte_i(eng_rx[8:1]),
      .last_o(pk_last), .bad_o(pk_bad), .we_o(mem_we_o),
      .page_o(mem_page_o), .step_o(mem_step_o), .data_o(mem_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_START1; issued <= 1'b0; go_q <= 1'b0; op_q <= OP_START;
         tx_q <= '0; nak_q <= 1'b0; pend <= 1'b0; bad_ack <= 1'b0;
         clr_q <= 1'b0; sys_rst_o <= 1'b1; err_o <= 1'b0;
      end else begin
         go_q  <= 1'b0;
         clr_q <= 1'b0;
         if (st == SQ_DONE || st == SQ_FAIL) begin
            if (pend) begin
               st <= SQ_START1; pend <= 1'b0; clr_q <= 1'b1;
               bad_ack <= 1'b0; err_o <= 1'b0;
            end
         end else if (eng_done) begin
            issued <= 1'b0;
            unique case (st)
               SQ_START1: st <= pend ? SQ_STOP : SQ_DEVW;
               SQ_DEVW, SQ_AH, SQ_AL: begin
                  if (eng_rx[0]) begin
                     bad_ack <= 1'b1; st <= SQ_STOP;
                  end else if (pend) st <= SQ_STOP;
                  else if (st == SQ_DEVW) st <= SQ_AH;
                  else if (st == SQ_AH)   st <= SQ_AL;
                  else                    st <= SQ_START2;
               end
               SQ_START2: st <= pend ? SQ_STOP : SQ_DEVR;
               SQ_DEVR: begin
                  if (eng_rx[0]) begin
                     bad_ack <= 1'b1; st <= SQ_STOP;
                  end else st <= SQ_READ;
               end
               SQ_READ: if (nak_q) st <= SQ_STOP;
               SQ_STOP: begin
                  if (pend) begin
                     st <= SQ_START1; pend <= 1'b0; clr_q <= 1'b1;
                     bad_ack <= 1'b0; err_o <= 1'b0;
                  end else if (bad_ack || pk_bad) begin
                     st <= SQ_FAIL; err_o <= 1'b1;
                  end else begin
                     st <= SQ_DONE; sys_rst_o <= 1'b0;
                  end
               end
               default: ;
            endcase
         end else if (!issued && !clr_q) begin
            go_q   <= 1'b1;
            issued <= 1'b1;
            unique case (st)
               SQ_START1, SQ_START2: op_q <= OP_START;
               SQ_DEVW: begin op_q <= OP_WR; tx_q <= {DEV_ID, 1'b0}; end
               SQ_AH, SQ_AL: begin op_q <= OP_WR; tx_q <= 8'h00; end
               SQ_DEVR: begin op_q <= OP_WR; tx_q <= {DEV_ID, 1'b1}; end
               SQ_READ: begin op_q <= OP_RD; nak_q <= pk_last | pend; end
               default: op_q <= OP_STOP;
            endcase
         end
         if (rl_edge) begin
            pend      <= 1'b1;
            sys_rst_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_o,
   input logic sda_oe_o,
   input logic sys_rst_o,
   input logic err_o,
   input logic mem_we_o
);
   // R3
   one_line_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!$stable(scl_o) && !$stable(sda_oe_o)));

   // R5
   write_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> sys_rst_o);

   // R12
   err_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> sys_rst_o);

   // R6
   bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst_o |-> (scl_o && !sda_oe_o));

   // R4
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);
endmodule

bind prom_boot_loader boot_loader_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
   .sys_rst_o(sys_rst_o), .err_o(err_o), .mem_we_o(mem_we_o)
);

// File: tb/sim_prom_boot_loader.sv
module sim_prom_boot_loader;
   localparam int CLK_P  = 10;
   localparam int PAGE_W = 2;
   localparam int STEP_W = 4;
   localparam int WORDS  = 2 ** (PAGE_W + STEP_W);
   localparam int IMG_B  = 2 * WORDS;
   localparam int NB     = IMG_B + 2;
   localparam int PW     = PAGE_W + STEP_W + 12;

   logic clk = 1'b0, rst_n = 1'b0, reload_i = 1'b0;
   logic scl_o, sda_oe_o, sys_rst_o, err_o, mem_we_o;
   logic [PAGE_W-1:0] mem_page_o;
   logic [STEP_W-1:0] mem_step_o;
   logic [11:0]       mem_data_o;
   logic sl_drv = 1'b0;
   wire  sda_line = !(sda_oe_o || sl_drv);

   always #(CLK_P/2) clk = ~clk;

   prom_boot_loader #(.CLK_DIV(2), .PAGE_W(PAGE_W), .STEP_W(STEP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .scl_o(scl_o),
      .sda_i(sda_line), .sda_oe_o(sda_oe_o), .sys_rst_o(sys_rst_o),
      .err_o(err_o), .mem_we_o(mem_we_o), .mem_page_o(mem_page_o),
      .mem_step_o(mem_step_o), .mem_data_o(mem_data_o)
   );

   int total = 0, bad = 0;
   bit done_flag = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- EEPROM model ----------------
   logic [7:0]  ee [0:NB-1];
   logic [15:0] ptr = '0, nack_at = 16'hFFFF, addr_seen = 16'hFFFF;
   logic [7:0]  sh = '0, devw_seen = '0, devr_seen = '0;
   int  bitc = 0, bidx = 0, stop_cnt = 0;
   bit  scl_p = 1, sda_p = 1, rd = 0, acked = 0, txing = 0, rxing = 0, txdone = 0;
   bit  nak_dev = 0;

   function automatic logic [7:0] ee_rd(input logic [15:0] a);
      return (int'(a) < NB) ? ee[a] : 8'hFF;
   endfunction

   always @(negedge clk) begin
      if (scl_o && scl_p && sda_p && !sda_line) begin
         rxing = 1; txing = 0; txdone = 0; bitc = 0; bidx = 0; sl_drv = 0;
      end else if (scl_o && scl_p && !sda_p && sda_line) begin
         rxing = 0; txing = 0; sl_drv = 0; stop_cnt++;
      end else if (!scl_p && scl_o) begin
         if (rxing && bitc < 8) sh = {sh[6:0], sda_line};
         if (txing && bitc == 8) begin
            if (sda_line) begin nack_at = ptr; txdone = 1; end
            else ptr = ptr + 16'd1;
         end
         bitc++;
      end else if (scl_p && !scl_o) begin
         if (rxing && bitc == 8) begin
            if (bidx == 0) begin
               acked = (sh[7:1] == 7'h50) && !nak_dev;
               rd = sh[0];
               if (sh[0]) devr_seen = sh; else devw_seen = sh;
            end else if (bidx == 1) ptr[15:8] = sh;
            else if (bidx == 2) begin ptr[7:0] = sh; addr_seen = ptr; end
            sl_drv = acked;
            bidx++;
         end else if (rxing && bitc == 9) begin
            sl_drv = 0; bitc = 0;
            if (bidx == 1 && rd && acked) begin
               rxing = 0; txing = 1; sl_drv = !ee_rd(ptr)[7];
            end
         end else if (txing && bitc >= 1 && bitc <= 7) begin
            sl_drv = !ee_rd(ptr)[7-bitc];
         end else if (txing && bitc == 8) begin
            sl_drv = 0;
         end else if (txing && bitc == 9) begin
            bitc = 0;
            if (txdone) txing = 0;
            else sl_drv = !ee_rd(ptr)[7];
         end
      end
      scl_p = scl_o; sda_p = sda_line;
   end

   // ---------------- scoreboard ----------------
   logic [PW-1:0] exp_q [$];
   bit sb_on = 0;
   int ld_wr = 0, p1_wr = 0, r3_viol = 0, r5_viol = 0, r12_viol = 0;
   logic pscl = 1, poe = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_o !== pscl && sda_oe_o !== poe) r3_viol++;
         if (mem_we_o && !sys_rst_o) r5_viol++;
         if (err_o && !sys_rst_o) r12_viol++;
         if (mem_we_o) begin
            ld_wr++;
            if (mem_page_o == PAGE_W'(1)) p1_wr++;
            if (sb_on) begin
               if (exp_q.size() == 0) chk("R4 unexpected write", 32'(mem_step_o), 32'hFFFF);
               else chk("R4 word", 32'({mem_page_o, mem_step_o, mem_data_o}), 32'(exp_q.pop_front()));
            end
         end
      end
      pscl = scl_o; poe = sda_oe_o;
   end

   task automatic build(input int seed, input int bad_word, input bit bad_sum);
      logic [15:0] s;
      s = '0;
      exp_q.delete();
      for (int i = 0; i < WORDS; i++) begin
         logic [11:0] w;
         logic [7:0]  hb;
         w  = 12'(i * 283 + seed * 97 + 5);
         hb = {4'h0, w[11:8]};
         if (i == bad_word) hb[7:4] = 4'h6;
         ee[2*i]   = hb;
         ee[2*i+1] = w[7:0];
         s = s + {8'd0, hb} + {8'd0, w[7:0]};
         exp_q.push_back({PAGE_W'(i >> STEP_W), STEP_W'(i), w});
      end
      if (bad_sum) s = s + 16'd1;
      ee[IMG_B]   = s[15:8];
      ee[IMG_B+1] = s[7:0];
   endtask

   task automatic wait_load();
      do @(negedge clk); while (!(sys_rst_o === 1'b0 || err_o === 1'b1));
   endtask

   task automatic reload(input bit do_chk);
      ld_wr = 0; p1_wr = 0;
      reload_i = 1'b1;
      repeat (4) @(negedge clk);
      if (do_chk) chk("R10 reset raised", 32'(sys_rst_o), 32'd1);
      reload_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      int st0;
      build(1, -1, 0);
      sb_on = 1;
      repeat (5) @(negedge clk);
      chk("R1 rst during reset", 32'(sys_rst_o), 32'd1);
      chk("R1 err during reset", 32'(err_o), 32'd0);
      chk("R1 scl idle", 32'(scl_o), 32'd1);
      chk("R1 sda released", 32'(sda_oe_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rst after release", 32'(sys_rst_o), 32'd1);

      wait_load();
      chk("R6 reset released", 32'(sys_rst_o), 32'd0);
      chk("R6 no error", 32'(err_o), 32'd0);
      chk("R6 bus idle", 32'({scl_o, sda_oe_o}), 32'b10);
      chk("R4 all words consumed", 32'(exp_q.size()), 32'd0);
      chk("R4 page 1 fully written", 32'(p1_wr), 32'(2 ** STEP_W));
      chk("R2 write address byte", 32'(devw_seen), 32'hA0);
      chk("R2 read address byte", 32'(devr_seen), 32'hA1);
      chk("R2 start address", 32'(addr_seen), 32'd0);
      chk("R2 NACK on last byte", 32'(nack_at), 32'(NB - 1));

      build(2, -1, 0);
      reload(1);
      chk("R10 err clear", 32'(err_o), 32'd0);
      wait_load();
      chk("R10 reload ok", 32'({sys_rst_o, err_o}), 32'b00);
      chk("R10 full rewrite", 32'(ld_wr), 32'(WORDS));

      build(3, 5, 0);
      reload(0);
      wait_load();
      chk("R7 nibble error flagged", 32'(err_o), 32'd1);
      chk("R7 reset held", 32'(sys_rst_o), 32'd1);
      chk("R7 words still written", 32'(exp_q.size()), 32'd0);

      build(4, -1, 1);
      reload(0);
      chk("R10 err cleared by reload", 32'(err_o), 32'd0);
      wait_load();
      chk("R8 checksum error", 32'(err_o), 32'd1);
      chk("R8 reset held", 32'(sys_rst_o), 32'd1);

      build(5, -1, 0);
      exp_q.delete();
      nak_dev = 1;
      st0 = stop_cnt;
      reload(0);
      wait_load();
      chk("R9 ack missing error", 32'(err_o), 32'd1);
      chk("R9 reset held", 32'(sys_rst_o), 32'd1);
      chk("R9 no writes", 32'(ld_wr), 32'd0);
      chk("R9 stop issued", 32'(stop_cnt - st0), 32'd1);
      nak_dev = 0;

      build(6, -1, 0);
      reload(0);
      while (ld_wr < 10) @(negedge clk);
      sb_on = 0;
      st0 = stop_cnt;
      reload_i = 1'b1;
      repeat (4) @(negedge clk);
      reload_i = 1'b0;
      while (stop_cnt == st0) @(negedge clk);
      chk("R11 reset held through abort", 32'(sys_rst_o), 32'd1);
      chk("R11 abort read NACKed early", 32'(nack_at < 16'(NB - 1)), 32'd1);
      build(6, -1, 0);
      ld_wr = 0;
      sb_on = 1;
      wait_load();
      chk("R11 restart ok", 32'({sys_rst_o, err_o}), 32'b00);
      chk("R11 all words rewritten", 32'(ld_wr), 32'(WORDS));
      chk("R11 queue drained", 32'(exp_q.size()), 32'd0);
      chk("R11 restart from 0", 32'(addr_seen), 32'd0);

      chk("R3 lines moved together", 32'(r3_viol), 32'd0);
      chk("R5 write outside reset", 32'(r5_viol), 32'd0);
      chk("R12 error without reset", 32'(r12_viol), 32'd0);
      summary();
   end
endmodule